// File: doc/BRIEF.md
# Posted-Write Real-Time Counter Register File

This block is a small memory-mapped timekeeping unit. It holds a seconds counter and a 15-bit sub-second counter, both driven by a 32.768 kHz tick-enable input. It also holds an alarm comparator on the seconds value, a control word, a sticky status word and an interrupt-enable word. Software reads any register in one cycle and always sees live values.

Writes to the timekeeping registers are posted. Only one such write can be pending at a time. It commits after a parameterised number of tick-enable cycles, and its outcome is reported through status flags. Two control bits lock the counters. While either lock is set, a counter write that reaches its commit point is refused and flagged as an error, and the counter keeps its value. Writes to the status and interrupt-enable words take effect at once. The interrupt output is the OR of the enabled status events.

Top module: `srtc_regfile`

## Requirements
- R1: After reset every register reads zero, with two exceptions: alarm seconds (0x08) reads 0xFFFFFFFF, and status (0x14) reads 0x00000200. The interrupt output is low.
- R2: The sub-second counter (0x04, 15 bits, upper bits read zero) and the seconds counter (0x00) advance only on cycles where tick_i is 1 and control bit 3 is 1. The sub-second counter wraps from 32767 to 0, and the seconds counter increments on that wrap.
- R3: When the seconds counter advances from 0xFFFFFFFF to 0, status bit 2 is set.
- R4: On every cycle where the seconds counter equals alarm seconds, status bit 4 is set. This does not apply while alarm seconds is 0xFFFFFFFF, which never sets the flag.
- R5: Status bits 8, 7, 4 and 2 are sticky and cleared by writing 1 to them. A 0 leaves them unchanged. A set in the same cycle wins over the clear.
- R6: Writes to 0x00, 0x04, 0x08, 0x0C and 0x10 are posted, and the target register stays unchanged until commit. While a write is pending, status bit 10 is 1 and bit 9 is 0; otherwise bit 10 is 0 and bit 9 is 1. The write commits on the WR_LAT-th tick after it is accepted. A successful commit sets status bit 8.
- R7: A posted write issued while another is pending is dropped and sets status bit 7 at once. The pending write still commits normally.
- R8: A posted write to 0x00 or 0x04 that commits while control bit 18 or bit 17 is set leaves the counter unchanged. It sets status bit 7, not bit 8.
- R9: Writes to 0x14 and 0x18 take effect on the next clock edge and do not change status bits 10 and 9.
- R10: Interrupt-enable (0x18) stores only bits 9, 8, 7 and 4. irq_o is high whenever any status bit in that set is 1 together with its enable bit.
- R11: On the edge where a counter write commits successfully, neither counter advances from the tick. The loaded value is visible in the next cycle.
- R12: Reads of unmapped addresses return zero. Writes to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 32.768 kHz tick enable, one cycle wide |
| addr_i | input | AW | Byte address of the access |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
Several properties are checked on every cycle. Frozen counters stay stable while counting is off. The sub-second counter steps by exactly one on each advance. A pending write keeps its target and data stable, and a dropped write leaves the pending one in flight. A locked counter commit always raises the error flag. An all-ones alarm never sets the alarm flag. Other behaviours need the bench's scenarios and its cycle-by-cycle reference model: the exact commit latency under dense and sparse ticks, set-over-clear on a still-matching alarm, the seconds overflow, and the suppressed advance on a counter load.

// File: rtl/srtc_pkg.sv
package srtc_pkg;
  typedef enum logic [2:0] {
    REG_SEC, REG_SUB, REG_ALM, REG_ALO, REG_CTL, REG_STS, REG_IEN, REG_NONE
  } reg_sel_e;

  localparam int unsigned CTL_RUN   = 3;
  localparam int unsigned CTL_SLOCK = 17;
  localparam int unsigned CTL_HLOCK = 18;

  localparam int unsigned ST_OVF  = 2;
  localparam int unsigned ST_ALM  = 4;
  localparam int unsigned ST_ERR  = 7;
  localparam int unsigned ST_DONE = 8;
  localparam int unsigned ST_NEXT = 9;
  localparam int unsigned ST_BUSY = 10;

  localparam logic [31:0] ST_W1C   = 32'h0000_0194;
  localparam logic [31:0] IRQ_MASK = 32'h0000_0390;

  function automatic reg_sel_e decode_addr(input logic [31:0] a);
    case (a)
      32'h00:  return REG_SEC;
      32'h04:  return REG_SUB;
      32'h08:  return REG_ALM;
      32'h0C:  return REG_ALO;
      32'h10:  return REG_CTL;
      32'h14:  return REG_STS;
      32'h18:  return REG_IEN;
      default: return REG_NONE;
    endcase
  endfunction
endpackage

// File: rtl/srtc_timebase.sv
module srtc_timebase #(
  parameter int unsigned SEC_W = 32,
  parameter int unsigned SUB_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             ld_sec_i,
  input  logic             ld_sub_i,
  input  logic [SEC_W-1:0] ld_val_i,
  output logic [SEC_W-1:0] sec_o,
  output logic [SUB_W-1:0] sub_o,
  output logic             sec_wrap_o
);
  logic [SEC_W-1:0] sec_q;
  logic [SUB_W-1:0] sub_q;
  logic             sub_last;

  assign sub_last   = &sub_q;
  assign sec_wrap_o = adv_i & sub_last & (&sec_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      sub_q <= '0;
    end else begin
      if (ld_sec_i)                sec_q <= ld_val_i;
      else if (adv_i && sub_last)  sec_q <= sec_q + 1'b1;
      if (ld_sub_i)                sub_q <= ld_val_i[SUB_W-1:0];
      else if (adv_i)              sub_q <= sub_q + 1'b1;
    end
  end

  assign sec_o = sec_q;
  assign sub_o = sub_q;

  AST_SUB_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !ld_sub_i |=> sub_q == SUB_W'($past(sub_q) + 1'b1)); // R2
  AST_SINGLE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ld_sec_i && ld_sub_i)); // R11
endmodule

// File: rtl/srtc_wr_engine.sv
module srtc_wr_engine import srtc_pkg::*; #(
  parameter int unsigned LAT = 4,
  parameter int unsigned DW  = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          req_i,
  input  reg_sel_e      sel_i,
  input  logic [DW-1:0] data_i,
  output logic          busy_o,
  output logic          commit_o,
  output logic          drop_o,
  output reg_sel_e      sel_o,
  output logic [DW-1:0] data_o
);
  localparam int unsigned CW = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LAT - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  reg_sel_e      sel_q;
  logic [DW-1:0] data_q;

  assign commit_o = busy_q & tick_i & (cnt_q == LAST);
  assign drop_o   = req_i & busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sel_q  <= REG_NONE;
      data_q <= '0;
    end else if (commit_o) begin
      busy_q <= 1'b0;
    end else if (req_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      sel_q  <= sel_i;
      data_q <= data_i;
    end else if (busy_q && tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign sel_o  = sel_q;
  assign data_o = data_q;

  AST_HOLD_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !commit_o |=> busy_o && $stable(sel_o) && $stable(data_o)); // R6
  AST_DROP_KEEPS_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o && !commit_o |=> busy_o); // R7
endmodule

// File: rtl/srtc_regfile.sv
module srtc_regfile import srtc_pkg::*; #(
  parameter int unsigned AW     = 8,
  parameter int unsigned WR_LAT = 4,
  parameter int unsigned SUB_W  = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic          irq_o
);
  localparam int unsigned DW = 32;
  localparam logic [DW-1:0] ALM_NONE = '1;

  reg_sel_e      acc_sel, cm_sel;
  logic          req, busy, commit, drop;
  logic [DW-1:0] cm_data;
  logic [DW-1:0] sec;
  logic [SUB_W-1:0] sub;
  logic          wrap, cm_cnt, locked, cm_ok, ld_sec, ld_sub, adv, alarm_hit;
  logic [DW-1:0] alm_q, alo_q, ctl_q, ien_q, flg_q, flg_set, flg_clr, status;

  assign acc_sel = decode_addr(32'(addr_i));
  assign req     = wr_i & (acc_sel inside {REG_SEC, REG_SUB, REG_ALM, REG_ALO, REG_CTL});

  srtc_wr_engine #(.LAT(WR_LAT), .DW(DW)) u_wr (
    .clk_i, .rst_ni, .tick_i,
    .req_i(req), .sel_i(acc_sel), .data_i(wdata_i),
    .busy_o(busy), .commit_o(commit), .drop_o(drop),
    .sel_o(cm_sel), .data_o(cm_data)
  );

  assign cm_cnt = cm_sel inside {REG_SEC, REG_SUB};
  assign locked = ctl_q[CTL_HLOCK] | ctl_q[CTL_SLOCK];
  assign cm_ok  = commit & ~(cm_cnt & locked);
  assign ld_sec = cm_ok & (cm_sel == REG_SEC);
  assign ld_sub = cm_ok & (cm_sel == REG_SUB);
  assign adv    = tick_i & ctl_q[CTL_RUN] & ~(ld_sec | ld_sub);

  srtc_timebase #(.SEC_W(DW), .SUB_W(SUB_W)) u_tb (
    .clk_i, .rst_ni, .adv_i(adv), .ld_sec_i(ld_sec), .ld_sub_i(ld_sub),
    .ld_val_i(cm_data), .sec_o(sec), .sub_o(sub), .sec_wrap_o(wrap)
  );

  assign alarm_hit = (alm_q != ALM_NONE) && (sec == alm_q);

  always_comb begin
    flg_set          = '0;
    flg_set[ST_DONE] = cm_ok;
    flg_set[ST_ERR]  = drop | (commit & ~cm_ok);
    flg_set[ST_ALM]  = alarm_hit;
    flg_set[ST_OVF]  = wrap;
    flg_clr = (wr_i && acc_sel == REG_STS) ? (wdata_i & ST_W1C) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_q <= ALM_NONE;
      alo_q <= '0;
      ctl_q <= '0;
      ien_q <= '0;
      flg_q <= '0;
    end else begin
      flg_q <= (flg_q & ~flg_clr) | flg_set;
      if (cm_ok && cm_sel == REG_ALM) alm_q <= cm_data;
      if (cm_ok && cm_sel == REG_ALO) alo_q <= cm_data;
      if (cm_ok && cm_sel == REG_CTL) ctl_q <= cm_data;
      if (wr_i && acc_sel == REG_IEN) ien_q <= wdata_i & IRQ_MASK;
    end
  end

  always_comb begin
    status          = flg_q;
    status[ST_BUSY] = busy;
    status[ST_NEXT] = ~busy;
  end

  assign irq_o = |(status & ien_q);

  always_comb begin
    case (acc_sel)
      REG_SEC: rdata_o = sec;
      REG_SUB: rdata_o = DW'(sub);
      REG_ALM: rdata_o = alm_q;
      REG_ALO: rdata_o = alo_q;
      REG_CTL: rdata_o = ctl_q;
      REG_STS: rdata_o = status;
      REG_IEN: rdata_o = ien_q;
      default: rdata_o = '0;
    endcase
  end

  AST_LOCKED_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit && cm_cnt && locked |=> flg_q[ST_ERR] && $past(sec) != sec - 32'd2); // R8
  AST_COUNTERS_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_q[CTL_RUN] && !commit |=> $stable(sec) && $stable(sub)); // R2
  AST_NO_ALARM_SENTINEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alm_q == ALM_NONE && !flg_q[ST_ALM] |=> !flg_q[ST_ALM]); // R4
  AST_DONE_ON_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit && !cm_cnt |=> flg_q[ST_DONE] && !busy); // R6
endmodule

// File: tb/sim_srtc_regfile.sv
module sim_srtc_regfile;
  localparam int unsigned WR_LAT = 4;
  localparam int unsigned SUB_W  = 15;
  localparam logic [31:0] SUBMAX = 32'd32767;

  logic        clk = 0, rst_n = 0, tick = 0, wr = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        irq;
  int          checks = 0, errors = 0, tick_every = 1, tdiv = 0;
  bit          finished = 0;

  srtc_regfile #(.AW(8), .WR_LAT(WR_LAT), .SUB_W(SUB_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  logic [31:0] m_sec, m_sub, m_alm, m_alo, m_ctl, m_ie, m_flg, m_wdata;
  logic [7:0]  m_waddr;
  bit          m_busy;
  int          m_cnt;
  logic [31:0] n_sec, n_sub, n_alm, n_alo, n_ctl, n_ie, n_wdata, s_flg, c_flg;
  logic [7:0]  n_waddr;
  bit          n_busy, commit, ok, cnt_tgt;
  int          n_cnt;

  function automatic bit slow_addr(input logic [7:0] a);
    return a == 8'h00 || a == 8'h04 || a == 8'h08 || a == 8'h0C || a == 8'h10;
  endfunction

  function automatic logic [31:0] m_status();
    return m_flg | (m_busy ? 32'h400 : 32'h200);
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return m_sec;   8'h04: return m_sub;
      8'h08: return m_alm;   8'h0C: return m_alo;
      8'h10: return m_ctl;   8'h14: return m_status();
      8'h18: return m_ie;    default: return 0;
    endcase
  endfunction

  function automatic string req_of(input logic [7:0] a);
    case (a)
      8'h00, 8'h04: return "R2";  8'h08: return "R4";
      8'h0C, 8'h10: return "R6";  8'h14: return "R5";
      8'h18: return "R10";        default: return "R12";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sec = 0; m_sub = 0; m_alm = '1; m_alo = 0; m_ctl = 0; m_ie = 0; m_flg = 0;
      m_busy = 0; m_cnt = 0; m_waddr = 0; m_wdata = 0;
    end else begin
      n_sec = m_sec; n_sub = m_sub; n_alm = m_alm; n_alo = m_alo; n_ctl = m_ctl;
      n_ie = m_ie; n_busy = m_busy; n_cnt = m_cnt; n_waddr = m_waddr; n_wdata = m_wdata;
      s_flg = 0; c_flg = 0;
      commit  = m_busy && tick && m_cnt == WR_LAT - 1;
      cnt_tgt = m_waddr == 8'h00 || m_waddr == 8'h04;
      ok      = commit && !(cnt_tgt && (m_ctl[18] || m_ctl[17]));
      if (m_alm != 32'hFFFF_FFFF && m_sec == m_alm) s_flg[4] = 1;
      if (tick && m_ctl[3] && !(ok && cnt_tgt)) begin
        if (m_sub == SUBMAX) begin
          n_sub = 0;
          if (m_sec == 32'hFFFF_FFFF) s_flg[2] = 1;
          n_sec = m_sec + 1;
        end else n_sub = m_sub + 1;
      end
      if (ok) begin
        case (m_waddr)
          8'h00: n_sec = m_wdata;
          8'h04: n_sub = m_wdata & SUBMAX;
          8'h08: n_alm = m_wdata;
          8'h0C: n_alo = m_wdata;
          default: n_ctl = m_wdata;
        endcase
        s_flg[8] = 1;
      end else if (commit) s_flg[7] = 1;
      if (commit) n_busy = 0;
      else if (m_busy && tick) n_cnt = m_cnt + 1;
      if (wr && slow_addr(addr)) begin
        if (m_busy) s_flg[7] = 1;
        else begin n_busy = 1; n_cnt = 0; n_waddr = addr; n_wdata = wdata; end
      end
      if (wr && addr == 8'h14) c_flg = wdata & 32'h194;
      if (wr && addr == 8'h18) n_ie = wdata & 32'h390;
      m_flg = (m_flg & ~c_flg) | s_flg;
      m_sec = n_sec; m_sub = n_sub; m_alm = n_alm; m_alo = n_alo; m_ctl = n_ctl;
      m_ie = n_ie; m_busy = n_busy; m_cnt = n_cnt; m_waddr = n_waddr; m_wdata = n_wdata;
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", r, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  initial forever begin
    @(negedge clk); #4;
    if (rst_n && !finished) begin
      chk({req_of(addr), " model rdata"}, rdata, m_read(addr));
      chk("R10 model irq", {31'd0, irq}, {31'd0, |(m_status() & m_ie)});
    end
  end

  initial forever begin
    @(negedge clk);
    tdiv = (tdiv + 1 >= tick_every) ? 0 : tdiv + 1;
    tick = (tdiv == 0);
  end

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string r);
    @(negedge clk); addr = a; #1; chk(r, rdata, exp);
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  logic [31:0] v1, prev;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(8'h00, 0, "R1 seconds");
    rd(8'h04, 0, "R1 subsec");
    rd(8'h08, 32'hFFFF_FFFF, "R1 alarm");
    rd(8'h10, 0, "R1 control");
    rd(8'h14, 32'h200, "R1 status");
    rd(8'h18, 0, "R1 irq enable");
    chk("R1 irq low", {31'd0, irq}, 0);
    // R10 / R9 immediate enable write
    wr_reg(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, 32'h390, "R10 enable mask");
    chk("R10 irq from write-next", {31'd0, irq}, 1);
    rd(8'h14, 32'h200, "R9 status untouched");
    wr_reg(8'h18, 0);
    rd(8'h18, 0, "R9 enable cleared");
    // R6 posted write latency
    wr_reg(8'h08, 5);
    rd(8'h14, 32'h400, "R6 busy");
    rd(8'h08, 32'hFFFF_FFFF, "R6 not yet committed");
    wait_idle();
    rd(8'h08, 5, "R6 committed");
    rd(8'h14, 32'h300, "R6 complete flag");
    // R5 write-one-to-clear
    wr_reg(8'h14, 0);
    rd(8'h14, 32'h300, "R5 zero no effect");
    wr_reg(8'h14, 32'h100);
    rd(8'h14, 32'h200, "R5 cleared");
    // R7 dropped write
    wr_reg(8'h0C, 32'hA5A5);
    wr_reg(8'h10, 32'h8);
    rd(8'h14, 32'h480, "R7 error while busy");
    wait_idle();
    rd(8'h0C, 32'hA5A5, "R7 pending committed");
    rd(8'h10, 0, "R7 dropped write");
    rd(8'h14, 32'h380, "R7 flags");
    wr_reg(8'h14, 32'h180);
    // R2 counting and R4 alarm
    wr_reg(8'h00, 4); wait_idle();
    wr_reg(8'h04, 32760); wait_idle();
    repeat (5) @(negedge clk);
    rd(8'h04, 32760, "R2 frozen subsec");
    wr_reg(8'h18, 32'h010);
    wr_reg(8'h10, 32'h8); wait_idle();
    repeat (20) @(negedge clk);
    rd(8'h00, 5, "R2 seconds advanced on wrap");
    rd(8'h14, 32'h310, "R4 alarm flag");
    chk("R10 irq on alarm", {31'd0, irq}, 1);
    wr_reg(8'h14, 32'h010);
    rd(8'h14, 32'h310, "R5 set wins over clear");
    // R2 freeze
    wr_reg(8'h10, 0); wait_idle();
    rd(8'h04, m_sub, "R2 read subsec");
    v1 = rdata;
    repeat (10) @(negedge clk);
    rd(8'h04, v1, "R2 subsec frozen");
    rd(8'h00, 5, "R2 seconds frozen");
    // R8 locks
    wr_reg(8'h10, 32'h2_0000); wait_idle();
    wr_reg(8'h14, 32'h1FF);
    wr_reg(8'h00, 32'h1234); wait_idle();
    rd(8'h00, 5, "R8 soft lock keeps seconds");
    rd(8'h14, 32'h290, "R8 soft lock error");
    wr_reg(8'h10, 32'h4_0000); wait_idle();
    wr_reg(8'h14, 32'h1FF);
    wr_reg(8'h04, 7); wait_idle();
    rd(8'h04, v1, "R8 hard lock keeps subsec");
    rd(8'h14, 32'h290, "R8 hard lock error");
    // R3 overflow, R4 sentinel
    wr_reg(8'h10, 0); wait_idle();
    wr_reg(8'h08, 32'hFFFF_FFFF); wait_idle();
    wr_reg(8'h00, 32'hFFFF_FFFF); wait_idle();
    wr_reg(8'h04, 32766); wait_idle();
    wr_reg(8'h14, 32'h1FF);
    rd(8'h14, 32'h200, "R4 all-ones alarm inert");
    wr_reg(8'h10, 32'h8); wait_idle();
    repeat (5) @(negedge clk);
    rd(8'h00, 0, "R3 seconds wrapped");
    rd(8'h14, 32'h304, "R3 overflow flag");
    wr_reg(8'h14, 32'h004);
    rd(8'h14, 32'h300, "R5 overflow cleared");
    // R11 load suppresses advance
    wr_reg(8'h00, 50);
    addr = 8'h04;
    prev = 0;
    forever begin
      @(negedge clk); #1;
      if (!m_busy) break;
      prev = rdata;
    end
    chk("R11 subsec held on load", rdata, prev);
    addr = 8'h00; #1;
    chk("R11 seconds loaded", rdata, 50);
    // R6 sparse ticks
    tick_every = 3;
    wr_reg(8'h0C, 32'h77);
    rd(8'h0C, 32'hA5A5, "R6 sparse not committed");
    wait_idle();
    rd(8'h0C, 32'h77, "R6 sparse committed");
    // R12 unmapped
    wr_reg(8'h20, 32'hFFFF);
    rd(8'h20, 0, "R12 unmapped read");
    rd(8'h14, 32'h300, "R12 no posted write");
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule